// File: doc/BRIEF.md
# Bus Comparator Trigger Unit

This block observes a processor's address and data buses and, on every cycle flagged as a valid bus cycle, evaluates two comparators, A and B, under one of four trigger modes. The modes are A-only, A-and-not-B, inside-range and outside-range. Each mode decides which of two sticky match flags it raises. The flags stay set until software-style clear logic pulses the clear strobe.

The block also produces a one-cycle trigger strobe. The strobe fires on the first bus cycle that meets the selected mode's full condition after reset or after a clear.

A tagging indicator marks an end-trigger run. In such a run only comparator A takes part, and every comparator B result is ignored. All comparisons are unsigned. Comparator B is matched against the data bus in A-and-not-B mode and against the address bus in the range modes.

Top module: `bus_trig_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, flag_a, flag_b and trig are all 0.
- R2: A cycle with bus_vld low changes neither flag and produces no trigger, whatever the other inputs hold.
- R3: With mode = 0 (A-only), a valid cycle with bus_addr equal to cmp_a sets flag_a and leaves flag_b alone.
- R4: With mode = 1 (A-and-not-B) and tag_end low, a valid cycle sets both flags only when bus_addr equals cmp_a and bus_data differs from the low DW bits of cmp_b. An address match alone, or a data mismatch alone, sets no flag.
- R5: With mode = 2 (inside range) and tag_end low, a valid cycle with cmp_a <= bus_addr <= cmp_b sets both flags. A cycle meeting only one bound sets no flag.
- R6: With mode = 3 (outside range), a valid cycle with bus_addr < cmp_a sets flag_a. A valid cycle with bus_addr > cmp_b sets flag_b (the second part applies only with tag_end low).
- R7: With tag_end high, comparator B is ignored, and flag_b is never set by the cycle. Only the A part decides: mode 1 uses bus_addr == cmp_a, mode 2 uses bus_addr >= cmp_a, and mode 3 uses bus_addr < cmp_a. When the A part holds, flag_a is set.
- R8: Flags are sticky until flag_clr. When flag_clr is high, both flags read 0 on the next cycle, and a match in that same cycle is discarded.
- R9: trig goes high for exactly one cycle. It rises in the cycle after the first valid bus cycle that sets a flag following reset or a clear. It stays low for later matches until the next flag_clr.
- R10: Comparisons are unsigned over the full AW-bit address. An address of all ones is above any smaller bound, and zero is below any non-zero bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Bus cycle valid strobe |
| bus_addr | input | AW | Address bus |
| bus_data | input | DW | Data bus |
| cmp_a | input | AW | Comparator A value |
| cmp_b | input | AW | Comparator B value (low DW bits used against data) |
| mode | input | 2 | 0 A-only, 1 A-and-not-B, 2 inside range, 3 outside range |
| flag_clr | input | 1 | Clears both flags and re-arms the trigger |
| tag_end | input | 1 | Tagged end-trigger run: ignore comparator B |
| flag_a | output | 1 | Sticky flag A |
| flag_b | output | 1 | Sticky flag B |
| trig | output | 1 | One-cycle trigger strobe |

## Verification
Each mode is driven with addresses placed exactly on, just below and just above both bounds, so that off-by-one errors and swapped bounds show up in the flags. A-and-not-B mode is tried with the address alone matching, the data alone differing, and both together, which tells the joint rule apart from either half acting by itself. Every mode is repeated with tag_end high to show that comparator B drops out. Clear strobes are placed on matching cycles, and extreme addresses are used, to separate clear priority and signed comparison from the intended behaviour.

// File: rtl/bus_trig_pkg.sv
package bus_trig_pkg;

    typedef enum logic [1:0] {
        MODE_A_ONLY  = 2'd0,
        MODE_A_NOT_B = 2'd1,
        MODE_INSIDE  = 2'd2,
        MODE_OUTSIDE = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic fa;
        logic fb;
        logic armed;
        logic trig;
    } trig_state_t;

    typedef struct packed {
        logic addr_eq_a;
        logic addr_lt_a;
        logic addr_gt_b;
        logic data_eq_b;
    } cmp_res_t;

endpackage

// File: rtl/bus_cmp_core.sv
module bus_cmp_core
    import bus_trig_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [AW-1:0] val_a,
    input  logic [AW-1:0] val_b,
    output cmp_res_t      res
);
    logic [DW-1:0] b_data;

    generate
        if (DW <= AW) begin : g_slice
            assign b_data = val_b[DW-1:0];
        end else begin : g_extend
            assign b_data = {{(DW-AW){1'b0}}, val_b};
        end
    endgenerate

    always_comb begin
        res.addr_eq_a = (addr == val_a);
        res.addr_lt_a = (addr <  val_a);
        res.addr_gt_b = (addr >  val_b);
        res.data_eq_b = (data == b_data);
    end
endmodule

// File: rtl/trig_mode_dec.sv
module trig_mode_dec
    import bus_trig_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       tag,
    input  cmp_res_t   res,
    output logic       hit_a,
    output logic       hit_b
);
    logic a_part;
    logic both;

    always_comb begin
        hit_a  = 1'b0;
        hit_b  = 1'b0;
        a_part = 1'b0;
        both   = 1'b0;
        unique case (mode)
            MODE_A_ONLY: begin
                hit_a = res.addr_eq_a;
            end
            MODE_A_NOT_B: begin
                a_part = res.addr_eq_a;
                both   = res.addr_eq_a & ~res.data_eq_b;
                hit_a  = tag ? a_part : both;
                hit_b  = tag ? 1'b0   : both;
            end
            MODE_INSIDE: begin
                a_part = ~res.addr_lt_a;
                both   = ~res.addr_lt_a & ~res.addr_gt_b;
                hit_a  = tag ? a_part : both;
                hit_b  = tag ? 1'b0   : both;
            end
            MODE_OUTSIDE: begin
                hit_a = res.addr_lt_a;
                hit_b = ~tag & res.addr_gt_b;
            end
            default: begin
                hit_a = 1'b0;
                hit_b = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bus_trig_unit.sv
module bus_trig_unit
    import bus_trig_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_vld,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] cmp_a,
    input  logic [AW-1:0] cmp_b,
    input  logic [1:0]    mode,
    input  logic          flag_clr,
    input  logic          tag_end,
    output logic          flag_a,
    output logic          flag_b,
    output logic          trig
);
    cmp_res_t    res;
    logic        hit_a;
    logic        hit_b;
    trig_state_t st_d;
    trig_state_t st_q;

    bus_cmp_core #(.AW(AW), .DW(DW)) u_cmp (
        .addr  (bus_addr),
        .data  (bus_data),
        .val_a (cmp_a),
        .val_b (cmp_b),
        .res   (res)
    );

    trig_mode_dec u_dec (
        .mode  (trig_mode_e'(mode)),
        .tag   (tag_end),
        .res   (res),
        .hit_a (hit_a),
        .hit_b (hit_b)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        if (flag_clr) begin
            st_d.fa    = 1'b0;
            st_d.fb    = 1'b0;
            st_d.armed = 1'b1;
        end else if (bus_vld) begin
            st_d.fa = st_q.fa | hit_a;
            st_d.fb = st_q.fb | hit_b;
            if ((hit_a | hit_b) && st_q.armed) begin
                st_d.trig  = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fa: 1'b0, fb: 1'b0, armed: 1'b1, trig: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_a = st_q.fa;
    assign flag_b = st_q.fb;
    assign trig   = st_q.trig;
endmodule

// File: rtl/bus_trig_chk.sv
module bus_trig_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_vld,
    input logic [1:0] mode,
    input logic       flag_clr,
    input logic       tag_end,
    input logic       flag_a,
    input logic       flag_b,
    input logic       trig
);
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_vld && !flag_clr) |=> ($stable(flag_a) && $stable(flag_b) && !trig));

    a_r4_r5_pair_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !flag_clr && !tag_end && (mode == 2'd1 || mode == 2'd2)
         && !flag_a && !flag_b) |=> (flag_a == flag_b));

    a_r7_tag_no_b: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && tag_end && !flag_clr && !flag_b) |=> !flag_b);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!flag_a && !flag_b));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && flag_a) |=> flag_a);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    a_r9_trig_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> (flag_a || flag_b));
endmodule

bind bus_trig_unit bus_trig_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_vld  (bus_vld),
    .mode     (mode),
    .flag_clr (flag_clr),
    .tag_end  (tag_end),
    .flag_a   (flag_a),
    .flag_b   (flag_b),
    .trig     (trig)
);

// File: tb/sim_bus_trig_unit.sv
module sim_bus_trig_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_vld = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic [AW-1:0] cmp_a = '0;
    logic [AW-1:0] cmp_b = '0;
    logic [1:0]    mode = 2'd0;
    logic          flag_clr = 1'b0;
    logic          tag_end = 1'b0;
    logic          flag_a;
    logic          flag_b;
    logic          trig;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit m_fa = 0, m_fb = 0, m_armed = 1, m_trig = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_trig_unit #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_addr(bus_addr),
        .bus_data(bus_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .mode(mode),
        .flag_clr(flag_clr), .tag_end(tag_end),
        .flag_a(flag_a), .flag_b(flag_b), .trig(trig)
    );

    task automatic check(string tag, bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int a, b, ad, dt;
        bit ha, hb;
        a = int'(cmp_a); b = int'(cmp_b); ad = int'(bus_addr); dt = int'(bus_data);
        ha = 0; hb = 0;
        case (mode)
            2'd0: ha = (ad == a);
            2'd1: if (tag_end) ha = (ad == a);
                  else begin ha = (ad == a) && (dt != (b % 256)); hb = ha; end
            2'd2: if (tag_end) ha = (ad >= a);
                  else begin ha = (ad >= a) && (ad <= b); hb = ha; end
            default: begin ha = (ad < a); hb = !tag_end && (ad > b); end
        endcase
        m_trig = 0;
        if (flag_clr) begin
            m_fa = 0; m_fb = 0; m_armed = 1;
        end else if (bus_vld) begin
            if (ha) m_fa = 1;
            if (hb) m_fb = 1;
            if ((ha || hb) && m_armed) begin m_trig = 1; m_armed = 0; end
        end
    endtask

    task automatic cyc(string tag, bit v, int ad, int dt, int a, int b,
                       int md, bit tg, bit clr);
        bus_vld = v; bus_addr = AW'(ad); bus_data = DW'(dt);
        cmp_a = AW'(a); cmp_b = AW'(b); mode = 2'(md); tag_end = tg; flag_clr = clr;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, flag_a, m_fa, "flag_a");
        check(tag, flag_b, m_fb, "flag_b");
        check(tag, trig, m_trig, "trig");
    endtask

    task automatic clr(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", flag_a, 0, "flag_a in reset");
        check("R1", flag_b, 0, "flag_b in reset");
        check("R1", trig, 0, "trig in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", flag_a, 0, "flag_a after reset");
        check("R1", trig, 0, "trig after reset");

        // R2: matching values but bus_vld low
        cyc("R2", 0, 16'h1234, 8'h00, 16'h1234, 16'h00FF, 0, 0, 0);
        cyc("R2", 0, 16'h0001, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        // R3: A-only
        cyc("R3", 1, 16'h1233, 8'h00, 16'h1234, 16'h0000, 0, 0, 0);
        cyc("R3", 1, 16'h1234, 8'h00, 16'h1234, 16'h0000, 0, 0, 0);
        cyc("R9", 1, 16'h1234, 8'h00, 16'h1234, 16'h0000, 0, 0, 0);
        clr("R8");
        // R4: A-and-not-B
        cyc("R4", 1, 16'h4000, 8'h55, 16'h4000, 16'h0055, 1, 0, 0);
        cyc("R4", 1, 16'h4001, 8'h11, 16'h4000, 16'h0055, 1, 0, 0);
        cyc("R4", 1, 16'h4000, 8'h56, 16'h4000, 16'hAB55, 1, 0, 0);
        cyc("R8", 1, 16'h0000, 8'h00, 16'h4000, 16'h0055, 1, 0, 0);
        clr("R8");
        // R5: inside range
        cyc("R5", 1, 16'h00FF, 8'h00, 16'h0100, 16'h0200, 2, 0, 0);
        cyc("R5", 1, 16'h0201, 8'h00, 16'h0100, 16'h0200, 2, 0, 0);
        cyc("R5", 1, 16'h0100, 8'h00, 16'h0100, 16'h0200, 2, 0, 0);
        clr("R8");
        cyc("R5", 1, 16'h0200, 8'h00, 16'h0100, 16'h0200, 2, 0, 0);
        clr("R8");
        // R6: outside range
        cyc("R6", 1, 16'h0150, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        cyc("R6", 1, 16'h0100, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        cyc("R6", 1, 16'h0201, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        cyc("R6", 1, 16'h00FF, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        clr("R8");
        cyc("R6", 1, 16'h00FF, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        clr("R8");
        // R7: tagged end-trigger
        cyc("R7", 1, 16'h4000, 8'h55, 16'h4000, 16'h0055, 1, 1, 0);
        clr("R8");
        cyc("R7", 1, 16'h0300, 8'h00, 16'h0100, 16'h0200, 2, 1, 0);
        clr("R8");
        cyc("R7", 1, 16'h0300, 8'h00, 16'h0100, 16'h0200, 3, 1, 0);
        cyc("R7", 1, 16'h0050, 8'h00, 16'h0100, 16'h0200, 3, 1, 0);
        cyc("R7", 1, 16'h00FF, 8'h00, 16'h0100, 16'h0200, 2, 1, 0);
        // R8: clear wins over a match
        cyc("R8", 1, 16'h0050, 8'h00, 16'h0100, 16'h0200, 3, 0, 1);
        cyc("R8", 0, 16'h0050, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        // R9: first match fires, later ones do not
        cyc("R9", 1, 16'h0150, 8'h00, 16'h0100, 16'h0200, 2, 0, 0);
        cyc("R9", 1, 16'h0160, 8'h00, 16'h0100, 16'h0200, 2, 0, 0);
        cyc("R9", 1, 16'h0050, 8'h00, 16'h0100, 16'h0200, 3, 0, 0);
        clr("R9");
        // R10: unsigned extremes
        cyc("R10", 1, 16'hFFFF, 8'h00, 16'h0001, 16'h7FFF, 3, 0, 0);
        clr("R10");
        cyc("R10", 1, 16'h0000, 8'h00, 16'h8000, 16'hFFFF, 3, 0, 0);
        clr("R10");
        cyc("R10", 1, 16'h9000, 8'h00, 16'h8000, 16'hFFFF, 2, 0, 0);
        clr("R10");
        cyc("R10", 1, 16'h7FFF, 8'h00, 16'h8000, 16'hFFFF, 2, 0, 0);
        cyc("R10", 1, 16'hFFFF, 8'h00, 16'h8000, 16'hFFFF, 2, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule